// File: doc/BRIEF.md
# Parallel flash command sequencer

This block connects a simple parallel request port to an on-chip user flash array. The array is driven through three active-low mode strobes (read, write, erase), a 9-bit word address and a 16-bit data word, and it answers with an active-low busy signal. The user side has narrower address and data fields, set by parameters. A request is a one-cycle pulse on exactly one of three request lines. It carries an address and, for a write, a data word.

An accepted request is widened to the array's field widths. The sequencer then lowers the matching strobe and keeps it low, with the operands frozen, for a minimum time. It waits for busy to go low and then to return high. For a read, it captures the top bits of the returned word. It ends the operation with a one-cycle `done` pulse. If busy does not respond within a fixed window, it ends with an `err` pulse instead. Both time limits are given in nanoseconds and converted to whole clock cycles, rounding up. Each operation covers a single word. Burst reads and page writes are not supported.

Top module: `pflash_seq`

## Requirements
- R1: A request with two or three of `req_rd`, `req_wr`, `req_er` high in the same cycle is dropped. No strobe goes low, `ready` stays high and neither `done` nor `err` pulses.
- R2: `ready` is high only when the sequencer is idle. Any request presented while `ready` is low is ignored and starts no further array access.
- R3: The array address `fl_addr` carries the user address in bits 8 down to 9-ADDR_W, with the remaining low bits 0. Bit 8 is therefore the sector select, equal to the user address MSB (0 selects sector 0, 1 selects sector 1).
- R4: For a write, `fl_wdata` carries the user data in bits 15 down to 16-DATA_W, with all remaining low bits 1.
- R5: For a read, `rd_data` equals `fl_rdata[15:16-DATA_W]` as sampled on the cycle busy is seen high again. It is valid while `done` is high and is held until the next read.
- R6: Only the strobe of the requested operation goes low (read: `fl_rd_n`, write: `fl_wr_n`, erase: `fl_er_n`). Once low, it stays low for at least HOLD_CYC = ceil(420 ns / clock period) cycles, which is 84 cycles at 5 ns.
- R7: `fl_addr` and `fl_wdata` do not change while a strobe is low.
- R8: If `fl_busy_n` is not seen low within WIN_CYC = ceil(210 ns / clock period) cycles of the strobe falling (42 cycles at 5 ns), the operation ends with a one-cycle `err` pulse and no `done`. The strobe is still held for its minimum time.
- R9: After busy returns high, `done` pulses for exactly one cycle, and `ready` is high on the following cycle.
- R10: After reset, all strobes are high, `ready` is high, `done` and `err` are low and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_rd | input | 1 | Read request pulse |
| req_wr | input | 1 | Write request pulse |
| req_er | input | 1 | Erase request pulse |
| req_addr | input | ADDR_W | User word address |
| req_wdata | input | DATA_W | User write data |
| ready | output | 1 | Idle, a request is accepted |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle busy-timeout pulse |
| rd_data | output | DATA_W | Captured read data |
| fl_rd_n | output | 1 | Array read strobe, active low |
| fl_wr_n | output | 1 | Array write strobe, active low |
| fl_er_n | output | 1 | Array erase strobe, active low |
| fl_addr | output | 9 | Padded array address |
| fl_wdata | output | 16 | Padded array write data |
| fl_rdata | input | 16 | Array read data |
| fl_busy_n | input | 1 | Array busy, active low |

## Verification
A wrong sequencer state shows up at the strobes within one cycle, as a strobe that rises early, a wrong strobe, or `ready` asserted mid-operation. The bench measures each strobe's low time against the hold limit and compares the captured operands with the padded request. A stuck or miscounted busy window appears as a missing or spurious `err` at the end of that same operation. Corrupted operand or read-data registers appear on `fl_addr`, `fl_wdata` or `rd_data` at the next `done`. A reference memory in the bench exposes them through write-then-read sequences.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  localparam int FL_AW = 9;
  localparam int FL_DW = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STROBE,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_FINISH
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_RD,
    OP_WR,
    OP_ER
  } op_e;

  // whole cycles covering a time in ns, rounded up
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/pfs_rst_sync.sv
module pfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_s_n = sync_q[STAGES-1];

endmodule

// File: rtl/pfs_req_decode.sv
module pfs_req_decode import pfs_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 10
) (
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic              req_er,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              accept,
  output op_e               dec_op,
  output logic [FL_AW-1:0]  pad_addr,
  output logic [FL_DW-1:0]  pad_wdata
);

  localparam int APAD = FL_AW - ADDR_W;
  localparam int DPAD = FL_DW - DATA_W;

  logic [2:0] req_vec;

  assign req_vec = {req_er, req_wr, req_rd};
  // exactly one request line high
  assign accept  = (req_vec != 3'b000) && ((req_vec & (req_vec - 3'b001)) == 3'b000);

  always_comb begin
    if (req_wr) begin
      dec_op = OP_WR;
    end else if (req_er) begin
      dec_op = OP_ER;
    end else begin
      dec_op = OP_RD;
    end
  end

  generate
    if (APAD > 0) begin : g_apad
      assign pad_addr = {req_addr, {APAD{1'b0}}};
    end else begin : g_afull
      assign pad_addr = req_addr;
    end
    if (DPAD > 0) begin : g_dpad
      assign pad_wdata = {req_wdata, {DPAD{1'b1}}};
    end else begin : g_dfull
      assign pad_wdata = req_wdata;
    end
  endgenerate

endmodule

// File: rtl/pfs_cnt.sv
module pfs_cnt #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic last
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign last = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en && !last) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && last) |=> last); // R6

endmodule

// File: rtl/pflash_seq.sv
module pflash_seq import pfs_pkg::*; #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 10,
  parameter int CLK_PS  = 5000,
  parameter int HOLD_NS = 420,
  parameter int BUSY_NS = 210
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic              req_er,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data,
  output logic              fl_rd_n,
  output logic              fl_wr_n,
  output logic              fl_er_n,
  output logic [8:0]        fl_addr,
  output logic [15:0]       fl_wdata,
  input  logic [15:0]       fl_rdata,
  input  logic              fl_busy_n
);

  localparam int HOLD_CYC = ns_to_cyc(HOLD_NS, CLK_PS);
  localparam int WIN_CYC  = ns_to_cyc(BUSY_NS, CLK_PS);

  logic rst_s_n;

  seq_state_e st_q, st_d;
  op_e        op_q;
  logic [FL_AW-1:0] addr_q;
  logic [FL_DW-1:0] wdat_q;
  logic       seen_q, seen_d;
  logic       tout_q, tout_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;

  logic       accept;
  op_e        dec_op;
  logic [FL_AW-1:0] dec_addr;
  logic [FL_DW-1:0] dec_wdat;

  logic       start;
  logic       strobe_on;
  logic       hold_clr, hold_en, hold_last;
  logic       win_en, win_last;
  logic       set_tout;
  logic       rdat_en;

  pfs_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  pfs_req_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .req_rd    (req_rd),
    .req_wr    (req_wr),
    .req_er    (req_er),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .accept    (accept),
    .dec_op    (dec_op),
    .pad_addr  (dec_addr),
    .pad_wdata (dec_wdat)
  );

  pfs_cnt #(.LIMIT(HOLD_CYC)) u_hold (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clr   (hold_clr),
    .en    (hold_en),
    .last  (hold_last)
  );

  pfs_cnt #(.LIMIT(WIN_CYC)) u_win (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clr   (hold_clr),
    .en    (win_en),
    .last  (win_last)
  );

  // control decode
  always_comb begin
    start     = (st_q == ST_IDLE) && accept;
    strobe_on = (st_q == ST_STROBE) || (st_q == ST_WAIT_LO);
    hold_clr  = (st_q == ST_IDLE);
    hold_en   = (st_q == ST_STROBE);
    win_en    = strobe_on && !seen_q && fl_busy_n;
    set_tout  = strobe_on && !seen_q && fl_busy_n && win_last;
    rdat_en   = (st_q == ST_WAIT_HI) && fl_busy_n && (op_q == OP_RD);
  end

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d = ST_STROBE;
        end
      end
      ST_STROBE: begin
        if (hold_last) begin
          if (tout_q || set_tout) begin
            st_d = ST_FINISH;
          end else if (seen_q || !fl_busy_n) begin
            st_d = ST_WAIT_HI;
          end else begin
            st_d = ST_WAIT_LO;
          end
        end
      end
      ST_WAIT_LO: begin
        if (!fl_busy_n) begin
          st_d = ST_WAIT_HI;
        end else if (set_tout) begin
          st_d = ST_FINISH;
        end
      end
      ST_WAIT_HI: begin
        if (fl_busy_n) begin
          st_d = ST_FINISH;
        end
      end
      ST_FINISH: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  // busy tracking flags
  always_comb begin
    seen_d = seen_q;
    tout_d = tout_q;
    if (st_q == ST_IDLE) begin
      seen_d = 1'b0;
      tout_d = 1'b0;
    end else begin
      if (strobe_on && !fl_busy_n) begin
        seen_d = 1'b1;
      end
      if (set_tout) begin
        tout_d = 1'b1;
      end
    end
  end

  assign rdat_d = fl_rdata[FL_DW-1 -: DATA_W];

  generate
    if (DATA_W < FL_DW) begin : g_rlo
      logic unused_rlo;
      assign unused_rlo = ^fl_rdata[FL_DW-DATA_W-1:0];
    end
  endgenerate

  // state and flag registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_IDLE;
      seen_q <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
      tout_q <= tout_d;
    end
  end

  // operand registers, loaded on accept
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      op_q   <= OP_RD;
      addr_q <= '0;
      wdat_q <= '0;
    end else if (start) begin
      op_q   <= dec_op;
      addr_q <= dec_addr;
      wdat_q <= dec_wdat;
    end
  end

  // read data register
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rdat_q <= '0;
    end else if (rdat_en) begin
      rdat_q <= rdat_d;
    end
  end

  assign ready    = (st_q == ST_IDLE);
  assign done     = (st_q == ST_FINISH) && !tout_q;
  assign err      = (st_q == ST_FINISH) && tout_q;
  assign rd_data  = rdat_q;
  assign fl_rd_n  = !(strobe_on && (op_q == OP_RD));
  assign fl_wr_n  = !(strobe_on && (op_q == OP_WR));
  assign fl_er_n  = !(strobe_on && (op_q == OP_ER));
  assign fl_addr  = addr_q;
  assign fl_wdata = wdat_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_s_n)
    $countones({~fl_rd_n, ~fl_wr_n, ~fl_er_n}) <= 1); // R6

  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(fl_rd_n & fl_wr_n & fl_er_n) |-> $past(hold_last)); // R6

  AST_OPND_STABLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!(fl_rd_n & fl_wr_n & fl_er_n) && $past(!(fl_rd_n & fl_wr_n & fl_er_n)))
      |-> ($stable(fl_addr) && $stable(fl_wdata))); // R7

  AST_MULTI_DROP: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ready && ($countones({req_rd, req_wr, req_er}) > 1))
      |=> (ready && fl_rd_n && fl_wr_n && fl_er_n)); // R1

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ready && (req_rd || req_wr || req_er)) |=> $stable(fl_addr)); // R2

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done || err) |=> (ready && !done && !err)); // R9

endmodule

// File: tb/pflash_seq_tb.sv
`timescale 1ns/1ps
module pflash_seq_tb;

  localparam int AW = 6;
  localparam int DW = 10;
  localparam int CLK_PS = 5000;
  localparam int HOLD_EXP = (420 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int NEVER = 100000;

  logic clk;
  logic rst_n;
  logic req_rd, req_wr, req_er;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic ready, done, err;
  logic [DW-1:0] rd_data;
  logic fl_rd_n, fl_wr_n, fl_er_n;
  logic [8:0] fl_addr;
  logic [15:0] fl_wdata;
  logic [15:0] fl_rdata;
  logic fl_busy_n;

  int checks;
  int errors;
  int cyc;

  pflash_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_rd(req_rd), .req_wr(req_wr), .req_er(req_er),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .done(done), .err(err), .rd_data(rd_data),
    .fl_rd_n(fl_rd_n), .fl_wr_n(fl_wr_n), .fl_er_n(fl_er_n),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .fl_busy_n(fl_busy_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- array model ----------------
  logic [15:0] mem [0:511];
  logic strobe_low;
  int   m_st, m_cnt, fall_cnt, low_len, cur_low, m_op;
  int   resp_delay, busy_len;
  bit   stab_bad;
  logic [8:0]  m_addr;
  logic [15:0] m_wdata;

  assign strobe_low = !(fl_rd_n && fl_wr_n && fl_er_n);

  initial begin
    m_st = 0; m_cnt = 0; fall_cnt = 0; low_len = 0; cur_low = 0; m_op = 0;
    resp_delay = 3; busy_len = 5; stab_bad = 1'b0;
    m_addr = '0; m_wdata = '0; fl_rdata = 16'h0000; fl_busy_n = 1'b1;
    for (int i = 0; i < 512; i++) mem[i] = 16'(i * 16'h9E37) ^ 16'h5A5A;
  end

  always @(posedge clk) begin
    if (strobe_low) begin
      if (cur_low == 0) begin
        m_addr   <= fl_addr;
        m_wdata  <= fl_wdata;
        fall_cnt <= fall_cnt + 1;
        m_op     <= !fl_rd_n ? 0 : (!fl_wr_n ? 1 : 2);
      end else if (fl_addr !== m_addr || fl_wdata !== m_wdata) begin
        stab_bad <= 1'b1;
      end
      cur_low <= cur_low + 1;
    end else if (cur_low != 0) begin
      low_len <= cur_low;
      cur_low <= 0;
    end
    case (m_st)
      0: if (strobe_low && cur_low == 0) begin m_st <= 1; m_cnt <= 1; end
      1: begin
        if (!strobe_low) m_st <= 0;
        else if (resp_delay != NEVER && m_cnt >= resp_delay) begin
          fl_busy_n <= 1'b0; m_st <= 2; m_cnt <= 1;
        end else m_cnt <= m_cnt + 1;
      end
      2: begin
        if (m_cnt >= busy_len) begin
          fl_busy_n <= 1'b1;
          m_st <= 3;
          if (m_op == 0) fl_rdata <= mem[m_addr];
          else if (m_op == 1) mem[m_addr] <= m_wdata;
          else mem[m_addr] <= 16'hFFFF;
        end else m_cnt <= m_cnt + 1;
      end
      default: if (!strobe_low) m_st <= 0;
    endcase
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_addr(input logic [AW-1:0] a);
    return {a, {(9-AW){1'b0}}};
  endfunction

  function automatic logic [15:0] exp_wd(input logic [DW-1:0] d);
    return {d, {(16-DW){1'b1}}};
  endfunction

  task automatic drive_req(input bit rd, input bit wr, input bit er,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_rd = rd; req_wr = wr; req_er = er; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_rd = 0; req_wr = 0; req_er = 0;
  endtask

  // one full single-word access with all port checks
  task automatic do_op(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int dly, input int blen);
    int n;
    int f0;
    logic [DW-1:0] exp_rd;
    bit got_done, got_err, exp_to;
    @(negedge clk);
    while (!ready) @(negedge clk);
    resp_delay = dly; busy_len = blen; stab_bad = 1'b0;
    exp_to = (dly == NEVER);
    exp_rd = mem[exp_addr(a)][15 -: DW];
    f0 = fall_cnt;
    drive_req(op == 0, op == 1, op == 2, a, d);
    n = 0;
    while (!(done || err) && n < 3000) begin @(negedge clk); n++; end
    got_done = done; got_err = err;
    chk(n < 3000, "R9", "operation completes", n, 0);
    chk(got_done == !exp_to, "R9", "done pulse", got_done, !exp_to);
    chk(got_err == exp_to, "R8", "err pulse on busy timeout", got_err, exp_to);
    chk(fall_cnt == f0 + 1, "R6", "one strobe per request", fall_cnt, f0 + 1);
    chk(m_op == op, "R6", "selected strobe", m_op, op);
    chk(m_addr == exp_addr(a), "R3", "padded address", m_addr, exp_addr(a));
    chk(m_addr[8] == a[AW-1], "R3", "sector select bit", m_addr[8], a[AW-1]);
    if (op == 1) chk(m_wdata == exp_wd(d), "R4", "padded write data", m_wdata, exp_wd(d));
    if (op == 0 && !exp_to) chk(rd_data == exp_rd, "R5", "read data", rd_data, exp_rd);
    @(negedge clk);
    chk(!done && !err && ready, "R9", "single-cycle pulse then ready",
        {done, err, ready}, 3'b001);
    chk(low_len >= HOLD_EXP, "R6", "strobe low time", low_len, HOLD_EXP);
    chk(!stab_bad, "R7", "operands stable under strobe", stab_bad, 0);
  endtask

  // ---------------- watchdog ----------------
  initial cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int seed;
    int f0;
    bit saw;
    checks = 0; errors = 0;
    req_rd = 0; req_wr = 0; req_er = 0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    seed = $urandom(32'h1F2E3D4C);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk(fl_rd_n && fl_wr_n && fl_er_n, "R10", "strobes idle high",
        {fl_rd_n, fl_wr_n, fl_er_n}, 3'b111);
    chk(ready && !done && !err, "R10", "ready high, pulses low", {ready, done, err}, 3'b100);
    chk(rd_data == '0, "R10", "read data cleared", rd_data, 0);

    // R3 sector corners, R4/R5 write then read back
    do_op(1, 6'h00, 10'h2A5, 3, 4);
    do_op(0, 6'h00, 10'h000, 2, 6);
    chk(rd_data == 10'h2A5, "R5", "read back written word", rd_data, 10'h2A5);
    do_op(1, 6'h3F, 10'h1C3, 5, 2);
    do_op(0, 6'h3F, 10'h000, 4, 3);
    chk(rd_data == 10'h1C3, "R5", "read back top sector", rd_data, 10'h1C3);
    do_op(0, 6'h20, 10'h000, 1, 1);
    do_op(0, 6'h1F, 10'h000, 7, 9);
    // erase then read gives all ones
    do_op(2, 6'h11, 10'h000, 3, 5);
    do_op(0, 6'h11, 10'h000, 3, 5);
    chk(rd_data == 10'h3FF, "R5", "erased word reads ones", rd_data, 10'h3FF);
    // busy responding late but inside the window, and long busy past the hold
    do_op(0, 6'h05, 10'h000, 30, 120);
    do_op(1, 6'h06, 10'h155, 25, 2);

    // R8 busy never responds
    do_op(0, 6'h0A, 10'h000, NEVER, 1);
    do_op(1, 6'h33, 10'h0F0, NEVER, 1);
    do_op(0, 6'h0B, 10'h000, 2, 2);

    // R1 multiple simultaneous requests are dropped
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      f0 = fall_cnt;
      saw = 1'b0;
      case (k)
        0: drive_req(1, 1, 0, 6'h15, 10'h111);
        1: drive_req(1, 0, 1, 6'h16, 10'h222);
        2: drive_req(0, 1, 1, 6'h17, 10'h333);
        default: drive_req(1, 1, 1, 6'h18, 10'h044);
      endcase
      for (int j = 0; j < 8; j++) begin
        if (!ready || done || err || strobe_low) saw = 1'b1;
        @(negedge clk);
      end
      chk(!saw && fall_cnt == f0, "R1", "multi request dropped", fall_cnt, f0);
    end

    // R2 requests while busy are ignored
    @(negedge clk);
    resp_delay = 4; busy_len = 6;
    f0 = fall_cnt;
    drive_req(0, 1, 0, 6'h09, 10'h0AB);
    repeat (10) @(negedge clk);
    chk(!ready, "R2", "ready low during operation", ready, 0);
    drive_req(0, 0, 1, 6'h22, 10'h000);
    while (!(done || err)) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(fall_cnt == f0 + 1, "R2", "busy-time request ignored", fall_cnt, f0 + 1);
    chk(m_op == 1 && m_addr == exp_addr(6'h09), "R2", "accepted op untouched",
        m_addr, exp_addr(6'h09));
    do_op(0, 6'h09, 10'h000, 2, 2);
    chk(rd_data == 10'h0AB, "R2", "only first write landed", rd_data, 10'h0AB);

    // constrained random accesses
    for (int r = 0; r < 40; r++) begin
      int op;
      int dly;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      op  = $urandom_range(2, 0);
      a   = AW'($urandom_range(63, 0));
      d   = DW'($urandom());
      dly = ($urandom_range(9, 0) == 0) ? NEVER : $urandom_range(30, 1);
      do_op(op, a, d, dly, $urandom_range(40, 1));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule